// File: doc/BRIEF.md
# Activity-Reloaded Watchdog Timer

This block is a watchdog counter that software sets up through four byte-wide registers: a control byte, a configuration byte, and the low and high bytes of a 16-bit reload count. Once a nonzero count is written, the counter steps down once per time unit. The unit is either one second, taken straight from an incoming one-per-second strobe, or one minute, made by a divide-by-60 prescaler on that strobe.

There is no dedicated kick register. The count is restored to the stored value whenever an enabled peripheral source reports activity. The four sources are an infrared-controller access, a mouse interrupt, a keyboard interrupt and a game-port read. Each restore takes effect a fixed number of clock cycles after the event.

When the count runs out, or software sets the force bit, the block latches a sticky status bit. Depending on the configuration it then pulses a keyboard-reset output, pulses a power-good output, holds a timeout level and raises one selected interrupt line. Writing zero to the control byte and to both count bytes parks the watchdog.

Top module: `actwd_top`

## Requirements
- R1: After reset every register reads 0x00, and the reset pulse, power-good pulse, timeout level and all interrupt lines are low.
- R2: Register addresses: 0 is control, 1 is configuration, 2 is count low and 3 is count high. Control bits 7, 6, 5 and 4 enable reload on infrared, mouse, keyboard and game-port activity. Control bit 1 forces a timeout and always reads 0. Control bit 0 is the status bit. Control bits 3:2 read 0. Configuration bit 7 selects seconds (1) or minutes (0). Configuration bit 6 enables the keyboard reset, bit 5 the timeout level, bit 4 the power-good pulse, and bits 3:0 pick the interrupt line. Configuration and count bytes read back as written.
- R3: In seconds mode, with reload value N written, the status bit sets at the clock edge that consumes the Nth second strobe after the count was loaded, and not before.
- R4: In minutes mode, one count unit is 60 second strobes. The prescaler is cleared whenever the count is loaded or reloaded.
- R5: An activity event on an enabled source reloads the count exactly RELOAD_DLY (default 4) clock cycles after the event edge. Until then the old count keeps running. Events on disabled sources have no effect.
- R6: The status bit sets on expiry. Writing 0 to control bit 0 clears it. Writing 1 to that bit leaves it unchanged.
- R7: Writing control with bit 1 set causes an immediate timeout: the status bit is set after that write edge.
- R8: On timeout, the keyboard-reset output and the power-good output each pulse high for exactly RST_PULSE (default 8) cycles, starting the cycle after the expiry edge. Each pulse fires only if its configuration enable is set.
- R9: The timeout output equals the status bit ANDed with configuration bit 5.
- R10: While the status bit is set, interrupt line k (bit k of the interrupt vector) is high when the interrupt-select field equals k, with k from 1 to 15. A select value of 0 raises no line, and at most one line is ever high.
- R11: With a zero reload value (control and count bytes written to zero) the counter stays idle, and no number of second strobes causes a timeout.
- R12: After expiry the count stays at zero and does not wrap or re-fire until it is reloaded or rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 8 | Register read data (combinational) |
| sec_tick_i | input | 1 | One-cycle strobe once per second |
| act_ir_i | input | 1 | Infrared-controller activity event |
| act_mouse_i | input | 1 | Mouse interrupt event |
| act_kbd_i | input | 1 | Keyboard interrupt event |
| act_game_i | input | 1 | Game-port read event |
| kbd_rst_o | output | 1 | Keyboard-reset pulse on timeout |
| tmo_o | output | 1 | Timeout level |
| pg_pulse_o | output | 1 | Power-good pulse on timeout |
| irq_o | output | IRQ_LINES | Interrupt lines, at most one high |

## Verification
The assertions assume that the second strobe and the activity inputs are single-cycle pulses, and that a pending reload is never cancelled by anything other than a count write. The stimulus raises every strobe and event for exactly one clock at a time. Register writes are issued on their own cycles, apart from the edges where the reload delay or a tick boundary is being measured. Timeout edges are placed on purpose at the cycle before a pending reload lands, so the behaviour at that boundary is exercised.

// File: rtl/actwd_pkg.sv
package actwd_pkg;

  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 2'd0,
    A_CFG    = 2'd1,
    A_CNT_LO = 2'd2,
    A_CNT_HI = 2'd3
  } reg_addr_e;

  localparam int CTRL_FORCE_BIT  = 1;
  localparam int CTRL_STATUS_BIT = 0;

  // activity enables, MSB first: infrared, mouse, keyboard, game port
  typedef struct packed {
    logic ir;
    logic mouse;
    logic kbd;
    logic game;
  } act_en_t;

  typedef struct packed {
    logic       unit_sec;
    logic       kbd_rst_en;
    logic       tmo_en;
    logic       pg_en;
    logic [3:0] irq_sel;
  } cfg_t;

endpackage

// File: rtl/actwd_regs.sv
module actwd_regs
  import actwd_pkg::*;
#(
  parameter bit WIDE_COUNT = 1'b1,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              expire_i,
  output act_en_t           act_en_o,
  output cfg_t              cfg_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              cnt_wr_o,
  output logic              force_o,
  output logic              status_o
);

  logic [3:0]        en_q, en_d;
  logic [DATA_W-1:0] cfg_q, cfg_d;
  logic [DATA_W-1:0] lo_q, lo_d;
  logic [DATA_W-1:0] hi_q;
  logic              st_q, st_d;
  logic              cw_q, cw_d;
  logic              ctrl_wr;

  assign ctrl_wr = wr_en_i && (wr_addr_i == A_CTRL);

  always_comb begin
    en_d  = en_q;
    cfg_d = cfg_q;
    lo_d  = lo_q;
    st_d  = st_q;
    cw_d  = 1'b0;
    if (wr_en_i) begin
      case (reg_addr_e'(wr_addr_i))
        A_CTRL: begin
          en_d = wr_data_i[7:4];
          st_d = st_q & wr_data_i[CTRL_STATUS_BIT];
        end
        A_CFG:    cfg_d = wr_data_i;
        A_CNT_LO: begin
          lo_d = wr_data_i;
          cw_d = 1'b1;
        end
        A_CNT_HI: cw_d = WIDE_COUNT;
        default:  ;
      endcase
    end
    if (expire_i) st_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      cfg_q <= '0;
      lo_q  <= '0;
      st_q  <= 1'b0;
      cw_q  <= 1'b0;
    end else begin
      en_q  <= en_d;
      cfg_q <= cfg_d;
      lo_q  <= lo_d;
      st_q  <= st_d;
      cw_q  <= cw_d;
    end
  end

  generate
    if (WIDE_COUNT) begin : g_hi
      logic [DATA_W-1:0] hi_d;
      always_comb begin
        hi_d = hi_q;
        if (wr_en_i && (wr_addr_i == A_CNT_HI)) hi_d = wr_data_i;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hi_q <= '0;
        else        hi_q <= hi_d;
      end
    end else begin : g_no_hi
      assign hi_q = '0;
    end
  endgenerate

  always_comb begin
    case (reg_addr_e'(rd_addr_i))
      A_CTRL:   rd_data_o = {en_q, 3'b000, st_q};
      A_CFG:    rd_data_o = cfg_q;
      A_CNT_LO: rd_data_o = lo_q;
      default:  rd_data_o = hi_q;
    endcase
  end

  assign act_en_o = act_en_t'(en_q);
  assign cfg_o    = cfg_t'(cfg_q);
  assign reload_o = {hi_q, lo_q};
  assign cnt_wr_o = cw_q;
  assign force_o  = ctrl_wr && wr_data_i[CTRL_FORCE_BIT];
  assign status_o = st_q;

  // R6
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q && !(ctrl_wr && !wr_data_i[CTRL_STATUS_BIT])) |=> st_q);
  // R6
  status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_i |=> st_q);

endmodule

// File: rtl/actwd_tick.sv
module actwd_tick #(
  parameter int MIN_DIV = 60,
  localparam int PW = (MIN_DIV > 1) ? $clog2(MIN_DIV) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_tick_i,
  input  logic unit_sec_i,
  input  logic clr_i,
  output logic unit_tick_o
);

  logic [PW-1:0] pre_q, pre_d;
  logic          wrap;

  assign wrap = (pre_q == PW'(MIN_DIV - 1));

  always_comb begin
    pre_d = pre_q;
    if (clr_i)                          pre_d = '0;
    else if (sec_tick_i && !unit_sec_i) pre_d = wrap ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign unit_tick_o = sec_tick_i && (unit_sec_i || wrap);

  // R4
  presc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= PW'(MIN_DIV - 1));
  // R4
  presc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> pre_q == '0);

endmodule

// File: rtl/actwd_core.sv
module actwd_core #(
  parameter int CNT_W      = 16,
  parameter int RELOAD_DLY = 4,
  localparam int DW = $clog2(RELOAD_DLY + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       act_i,
  input  logic [3:0]       act_en_i,
  input  logic [CNT_W-1:0] reload_val_i,
  input  logic             load_i,
  input  logic             unit_tick_i,
  input  logic             force_i,
  output logic             expire_o,
  output logic             presc_clr_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DW-1:0]    dly_q, dly_d;
  logic             busy_q, busy_d;
  logic             hit, reload_now, armed, cnt_expire;

  assign hit        = |(act_i & act_en_i);
  assign reload_now = busy_q && (dly_q == '0);
  assign armed      = (reload_val_i != '0);

  always_comb begin
    cnt_d  = cnt_q;
    dly_d  = dly_q;
    busy_d = busy_q;
    if (busy_q && dly_q != '0) dly_d = dly_q - 1'b1;
    if (reload_now) busy_d = 1'b0;
    if (hit) begin
      busy_d = 1'b1;
      dly_d  = DW'(RELOAD_DLY - 1);
    end
    if (load_i) begin
      cnt_d  = reload_val_i;
      busy_d = 1'b0;
    end else if (reload_now) begin
      cnt_d = reload_val_i;
    end else if (unit_tick_i && armed && cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      dly_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      dly_q  <= dly_d;
      busy_q <= busy_d;
    end
  end

  assign cnt_expire  = !load_i && !reload_now && unit_tick_i && armed &&
                       (cnt_q == CNT_W'(1));
  assign expire_o    = cnt_expire || force_i;
  assign presc_clr_o = load_i || reload_now;

  // R12
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !load_i && !reload_now) |=> cnt_q == '0);
  // R3
  no_count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !reload_now) |=> cnt_q <= $past(cnt_q));
  // R5
  reload_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !load_i) |=> busy_q);

endmodule

// File: rtl/actwd_pulse.sv
module actwd_pulse #(
  parameter int WIDTH = 8,
  localparam int CW = $clog2(WIDTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic pulse_o
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start_i)            cnt_d = CW'(WIDTH);
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign pulse_o = (cnt_q != '0);

  // R8
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> pulse_o);
  // R8
  pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_o && cnt_q == CW'(1) && !start_i) |=> !pulse_o);

endmodule

// File: rtl/actwd_top.sv
module actwd_top
  import actwd_pkg::*;
#(
  parameter bit WIDE_COUNT = 1'b1,
  parameter int MIN_DIV    = 60,
  parameter int RELOAD_DLY = 4,
  parameter int RST_PULSE  = 8,
  parameter int IRQ_LINES  = 16,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  input  logic [ADDR_W-1:0]    rd_addr_i,
  output logic [DATA_W-1:0]    rd_data_o,
  input  logic                 sec_tick_i,
  input  logic                 act_ir_i,
  input  logic                 act_mouse_i,
  input  logic                 act_kbd_i,
  input  logic                 act_game_i,
  output logic                 kbd_rst_o,
  output logic                 tmo_o,
  output logic                 pg_pulse_o,
  output logic [IRQ_LINES-1:0] irq_o
);

  act_en_t          act_en;
  cfg_t             cfg;
  logic [CNT_W-1:0] reload_val;
  logic             cnt_wr, force_req, status, expire;
  logic             unit_tick, presc_clr;

  actwd_regs #(.WIDE_COUNT(WIDE_COUNT)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .expire_i  (expire),
    .act_en_o  (act_en),
    .cfg_o     (cfg),
    .reload_o  (reload_val),
    .cnt_wr_o  (cnt_wr),
    .force_o   (force_req),
    .status_o  (status)
  );

  actwd_tick #(.MIN_DIV(MIN_DIV)) u_tick (
    .clk         (clk),
    .rst_n       (rst_n),
    .sec_tick_i  (sec_tick_i),
    .unit_sec_i  (cfg.unit_sec),
    .clr_i       (presc_clr),
    .unit_tick_o (unit_tick)
  );

  actwd_core #(.CNT_W(CNT_W), .RELOAD_DLY(RELOAD_DLY)) u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .act_i        ({act_ir_i, act_mouse_i, act_kbd_i, act_game_i}),
    .act_en_i     (act_en),
    .reload_val_i (reload_val),
    .load_i       (cnt_wr),
    .unit_tick_i  (unit_tick),
    .force_i      (force_req),
    .expire_o     (expire),
    .presc_clr_o  (presc_clr)
  );

  actwd_pulse #(.WIDTH(RST_PULSE)) u_kbd_pulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (expire && cfg.kbd_rst_en),
    .pulse_o (kbd_rst_o)
  );

  actwd_pulse #(.WIDTH(RST_PULSE)) u_pg_pulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (expire && cfg.pg_en),
    .pulse_o (pg_pulse_o)
  );

  assign tmo_o = status && cfg.tmo_en;

  generate
    for (genvar k = 0; k < IRQ_LINES; k++) begin : g_irq
      if (k == 0) begin : g_none
        assign irq_o[k] = 1'b0;
      end else begin : g_line
        assign irq_o[k] = status && (cfg.irq_sel == 4'(k));
      end
    end
  endgenerate

  // R10
  irq_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_o));
  // R9
  tmo_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_o |-> status);
  // R7
  force_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_req |=> status);

endmodule

// File: tb/actwd_top_test.sv
module actwd_top_test;

  localparam int W = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic [1:0] rd_addr;
  logic [7:0] rd_data;
  logic       sec_tick, a_ir, a_mouse, a_kbd, a_game;
  logic       kbd_rst, tmo, pg;
  logic [15:0] irq;

  always #10 clk = ~clk;

  actwd_top uut (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .sec_tick_i(sec_tick),
    .act_ir_i(a_ir), .act_mouse_i(a_mouse), .act_kbd_i(a_kbd), .act_game_i(a_game),
    .kbd_rst_o(kbd_rst), .tmo_o(tmo), .pg_pulse_o(pg), .irq_o(irq)
  );

  typedef struct {
    string       req;
    int          sel;
    logic [15:0] exp;
  } item_t;

  item_t sbq[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  function automatic logic [15:0] observe(int sel);
    case (sel)
      0:       return {8'h00, rd_data};
      1:       return {15'd0, kbd_rst};
      2:       return {15'd0, tmo};
      3:       return {15'd0, pg};
      default: return irq;
    endcase
  endfunction

  // monitor: pops expected items and compares with what the design shows
  initial begin
    forever begin
      wait (sbq.size() != 0);
      #1;
      while (sbq.size() != 0) begin
        item_t it;
        logic [15:0] got;
        it  = sbq.pop_front();
        got = observe(it.sel);
        checks++;
        if (got !== it.exp) begin
          errors++;
          $display("FAIL %s: sel=%0d actual=%h expected=%h", it.req, it.sel, got, it.exp);
        end
      end
    end
  end

  task automatic chk_reg(string req, logic [1:0] a, logic [7:0] e);
    rd_addr = a;
    sbq.push_back('{req, 0, {8'h00, e}});
    #2;
  endtask

  task automatic chk_out(string req, int sel, logic [15:0] e);
    sbq.push_back('{req, sel, e});
    #2;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick();
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic act(int which);
    case (which)
      0: a_ir = 1'b1;
      1: a_mouse = 1'b1;
      2: a_kbd = 1'b1;
      default: a_game = 1'b1;
    endcase
    @(negedge clk);
    a_ir = 1'b0; a_mouse = 1'b0; a_kbd = 1'b0; a_game = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    sec_tick = 1'b0; a_ir = 1'b0; a_mouse = 1'b0; a_kbd = 1'b0; a_game = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // R1 reset state
    chk_reg("R1 ctrl", 2'd0, 8'h00);
    chk_reg("R1 cfg", 2'd1, 8'h00);
    chk_reg("R1 cnt_lo", 2'd2, 8'h00);
    chk_reg("R1 cnt_hi", 2'd3, 8'h00);
    cyc(1);
    chk_out("R1 kbd_rst", 1, 16'h0);
    chk_out("R1 tmo", 2, 16'h0);
    chk_out("R1 pg", 3, 16'h0);
    chk_out("R1 irq", 4, 16'h0);
    cyc(1);

    // R2 register map: seconds, kbd reset, timeout level, irq line 5
    wr(2'd1, 8'hE5);
    wr(2'd0, 8'hFC);
    wr(2'd2, 8'h03);
    wr(2'd3, 8'h00);
    cyc(1);
    chk_reg("R2 ctrl", 2'd0, 8'hF0);
    chk_reg("R2 cfg", 2'd1, 8'hE5);
    chk_reg("R2 cnt_lo", 2'd2, 8'h03);
    chk_reg("R2 cnt_hi", 2'd3, 8'h00);
    cyc(1);

    // R3 seconds countdown of 3
    ticks(2);
    chk_reg("R3 no early expiry", 2'd0, 8'hF0);
    tick();
    chk_reg("R3 expiry", 2'd0, 8'hF1);
    chk_out("R8 kbd pulse start", 1, 16'h1);
    chk_out("R9 tmo level", 2, 16'h1);
    chk_out("R10 irq line 5", 4, 16'h0020);
    cyc(W - 1);
    chk_out("R8 kbd pulse last", 1, 16'h1);
    chk_out("R8 pg disabled", 3, 16'h0);
    cyc(1);
    chk_out("R8 kbd pulse end", 1, 16'h0);

    // R12 no wrap or re-fire after expiry
    ticks(3);
    chk_out("R12 no refire", 1, 16'h0);
    chk_reg("R12 status kept", 2'd0, 8'hF1);
    cyc(1);

    // R6 sticky status
    wr(2'd0, 8'hF1);
    chk_reg("R6 write one keeps", 2'd0, 8'hF1);
    wr(2'd0, 8'hF0);
    chk_reg("R6 write zero clears", 2'd0, 8'hF0);
    chk_out("R9 tmo follows status", 2, 16'h0);
    chk_out("R10 irq clear", 4, 16'h0);
    cyc(1);

    // R5 reload from infrared activity
    act(0);
    cyc(4);
    ticks(2);
    chk_reg("R5 reloaded count", 2'd0, 8'hF0);
    act(0);
    cyc(2);
    tick();
    chk_reg("R5 reload not before delay", 2'd0, 8'hF1);
    cyc(12);
    wr(2'd0, 8'h80);

    // R5 disabled source (only infrared enabled, mouse event)
    ticks(2);
    act(1);
    cyc(4);
    tick();
    chk_reg("R5 disabled source ignored", 2'd0, 8'h81);
    cyc(12);
    wr(2'd0, 8'h80);
    chk_reg("R6 cleared", 2'd0, 8'h80);
    cyc(1);

    // R7 force
    wr(2'd0, 8'h82);
    chk_reg("R7 force sets status", 2'd0, 8'h81);
    cyc(12);
    wr(2'd0, 8'h80);

    // R8 power-good pulse only; R10 select 0
    wr(2'd1, 8'h90);
    wr(2'd0, 8'h82);
    chk_out("R8 pg start", 3, 16'h1);
    chk_out("R8 kbd disabled", 1, 16'h0);
    chk_out("R9 tmo disabled", 2, 16'h0);
    chk_out("R10 select zero", 4, 16'h0);
    cyc(W - 1);
    chk_out("R8 pg last", 3, 16'h1);
    cyc(1);
    chk_out("R8 pg end", 3, 16'h0);
    wr(2'd0, 8'h80);

    // R4 minutes mode, one minute
    wr(2'd1, 8'h20);
    wr(2'd2, 8'h01);
    wr(2'd3, 8'h00);
    cyc(1);
    ticks(59);
    chk_out("R4 not at 59 s", 2, 16'h0);
    tick();
    chk_out("R4 expiry at 60 s", 2, 16'h1);
    wr(2'd0, 8'h80);
    chk_out("R4 cleared", 2, 16'h0);
    // R4 prescaler cleared on reload
    ticks(50);
    act(0);
    cyc(4);
    ticks(59);
    chk_out("R4 prescaler restarted", 2, 16'h0);
    tick();
    chk_out("R4 expiry after restart", 2, 16'h1);

    // R11 zero count stays idle
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h00);
    wr(2'd1, 8'hE0);
    cyc(1);
    ticks(10);
    chk_reg("R11 idle status", 2'd0, 8'h00);
    chk_out("R11 idle tmo", 2, 16'h0);
    chk_out("R11 idle kbd", 1, 16'h0);
    cyc(2);
    finish_run();
  end

endmodule